// File: doc/BRIEF.md
# Touch Button Detector with Baseline Tracking

This block turns a stream of raw capacitance counts from one sensor into a debounced touch state. Every accepted sample can first be smoothed by a moving average over 1, 2, 4 or 8 samples. It is then compared with an adaptive baseline. The positive difference, filtered count minus baseline, is tested against a finger threshold with a hysteresis band on each side. A touch is reported only after a programmed number of consecutive samples qualify.

The baseline follows slow upward drift through a bucket. Small positive differences add to the bucket, and the baseline steps up by one when the bucket fills. Sustained large negative deviations reload the baseline from the current count, when auto-reset is enabled. The filtered count, the baseline and the difference are all available as 16-bit outputs. The analog measurement is outside this block. All configuration values are plain inputs that the surrounding logic holds.

Top module: `touch_detect`

## Requirements
- R1: While reset is asserted and after its release, before any sample, touch, raw_out, base_out and diff_out are all zero.
- R2: The first sample accepted after reset loads the baseline with the filtered count, reports diff_out = 0 and makes no touch decision.
- R3: For each accepted sample (smp_vld high at a rising edge), all outputs update at that edge. diff_out is the filtered count minus the baseline held before the sample when the count is at least that baseline, and 0 otherwise. Without smp_vld the outputs hold.
- R4: With cfg_avg_en = 1, the filtered count is the floor mean of the current raw sample and the previous 2^k - 1 accepted raw samples, where k = cfg_avg_ord (0..3) and history is zero after reset. With cfg_avg_en = 0 the raw sample passes unchanged. History shifts on every accepted sample in both cases.
- R5: When not touched and the difference is below cfg_noise_th, the difference is added to the bucket. When the bucket sum reaches cfg_bucket_th, the baseline rises by exactly one (saturating at 0xFFFF) and the bucket clears. A difference at or above cfg_noise_th leaves bucket and baseline unchanged.
- R6: A sample more than cfg_neg_th below the baseline advances a consecutive counter; any other sample clears it. With cfg_auto_rst = 1, the sample that makes the counter reach cfg_low_rst (0 acts as 1) reloads the baseline with the filtered count and clears the bucket and the counter.
- R7: With cfg_auto_rst = 0, the baseline is never reloaded downward.
- R8: Touch sets after cfg_debounce consecutive samples (0 acts as 1) with difference >= cfg_finger_th + cfg_hyst. A non-qualifying sample restarts the count.
- R9: While touched, a sample with difference + cfg_hyst < cfg_finger_th clears touch in that same sample.
- R10: While touched, the bucket is frozen and the baseline does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Raw sample strobe |
| smp_raw | input | 16 | Raw capacitance count |
| cfg_avg_en | input | 1 | Averaging enable |
| cfg_avg_ord | input | 2 | Averaging order, 2^k samples |
| cfg_finger_th | input | 8 | Finger threshold |
| cfg_hyst | input | 8 | Hysteresis margin |
| cfg_debounce | input | 8 | Consecutive samples to set touch |
| cfg_noise_th | input | 8 | Bucket admission limit |
| cfg_bucket_th | input | 8 | Bucket level for a baseline step |
| cfg_neg_th | input | 8 | Negative deviation limit |
| cfg_low_rst | input | 8 | Negative samples before reload |
| cfg_auto_rst | input | 1 | Enables baseline reload |
| touch | output | 1 | Debounced touch state |
| raw_out | output | 16 | Last filtered count |
| base_out | output | 16 | Current baseline |
| diff_out | output | 16 | Last difference count |

## Verification
A baseline reload and a touch release can fall on the same sample. A pressed sensor whose count drops far below its baseline meets the reload condition and, with a zero difference, the release condition at once. The bench presses the sensor with a debounce of one and a reload count of one, then drives a sample well below the baseline. It checks that touch clears and that base_out equals the new filtered count after the same edge. A bench model computes the expected values arithmetically for every sample of the sweeps, including all four averaging orders with and without averaging.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam int RAW_W_DEF = 16;
  localparam int CFG_W_DEF = 8;
  localparam int ORD_W_DEF = 2;
endpackage

// File: rtl/touch_avg.sv
module touch_avg #(
  parameter int RAW_W = touch_pkg::RAW_W_DEF,
  parameter int ORD_W = touch_pkg::ORD_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [RAW_W-1:0] smp_raw,
  input  logic             avg_en,
  input  logic [ORD_W-1:0] avg_ord,
  output logic [RAW_W-1:0] filt
);
  localparam int MAXORD = (1 << ORD_W) - 1;
  localparam int HIST   = (1 << MAXORD) - 1;
  localparam int SUM_W  = RAW_W + MAXORD;

  logic [RAW_W-1:0] hist_q [HIST];
  logic [RAW_W-1:0] hist_d [HIST];
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] mean;

  genvar g;
  generate
    for (g = 0; g < HIST; g++) begin : g_slot
      if (g == 0) begin : g_head
        assign hist_d[g] = smp_raw;
      end else begin : g_tail
        assign hist_d[g] = hist_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hist_q[g] <= '0;
        else if (smp_vld) hist_q[g] <= hist_d[g];
      end
    end
  endgenerate

  always_comb begin
    acc = SUM_W'(smp_raw);
    for (int i = 0; i < HIST; i++) begin
      if (32'(i) + 32'd1 < (32'd1 << avg_ord)) acc = acc + SUM_W'(hist_q[i]);
    end
    mean = acc >> avg_ord;
  end

  assign filt = avg_en ? mean[RAW_W-1:0] : smp_raw;
endmodule

// File: rtl/touch_base.sv
module touch_base #(
  parameter int RAW_W = touch_pkg::RAW_W_DEF,
  parameter int CFG_W = touch_pkg::CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [RAW_W-1:0] filt,
  input  logic             touched,
  input  logic [CFG_W-1:0] noise_th,
  input  logic [CFG_W-1:0] bucket_th,
  input  logic [CFG_W-1:0] neg_th,
  input  logic [CFG_W-1:0] low_rst,
  input  logic             auto_rst,
  output logic [RAW_W-1:0] base,
  output logic             init
);
  logic [RAW_W-1:0] base_q, base_d;
  logic [CFG_W-1:0] bucket_q, bucket_d;
  logic [CFG_W-1:0] neg_q, neg_d;
  logic             init_q, init_d;
  logic [RAW_W-1:0] pos, below;
  logic [CFG_W:0]   bsum, ncnt, lim;

  always_comb begin
    base_d   = base_q;
    bucket_d = bucket_q;
    neg_d    = neg_q;
    init_d   = init_q;
    pos      = filt - base_q;
    below    = base_q - filt;
    bsum     = {1'b0, bucket_q} + {1'b0, pos[CFG_W-1:0]};
    ncnt     = {1'b0, neg_q} + {{CFG_W{1'b0}}, 1'b1};
    lim      = (low_rst == '0) ? {{CFG_W{1'b0}}, 1'b1} : {1'b0, low_rst};
    if (smp_vld) begin
      if (!init_q) begin
        base_d   = filt;
        init_d   = 1'b1;
        bucket_d = '0;
        neg_d    = '0;
      end else if (filt >= base_q) begin
        neg_d = '0;
        if (!touched && (pos < RAW_W'(noise_th))) begin
          if (bsum >= {1'b0, bucket_th}) begin
            bucket_d = '0;
            if (base_q != '1) base_d = base_q + RAW_W'(1);
          end else begin
            bucket_d = bsum[CFG_W-1:0];
          end
        end
      end else if (below > RAW_W'(neg_th)) begin
        if (auto_rst && (ncnt >= lim)) begin
          base_d   = filt;
          neg_d    = '0;
          bucket_d = '0;
        end else begin
          neg_d = ncnt[CFG_W] ? '1 : ncnt[CFG_W-1:0];
        end
      end else begin
        neg_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      bucket_q <= '0;
      neg_q    <= '0;
      init_q   <= 1'b0;
    end else if (smp_vld) begin
      base_q   <= base_d;
      bucket_q <= bucket_d;
      neg_q    <= neg_d;
      init_q   <= init_d;
    end
  end

  assign base = base_q;
  assign init = init_q;
endmodule

// File: rtl/touch_deb.sv
module touch_deb #(
  parameter int RAW_W = touch_pkg::RAW_W_DEF,
  parameter int CFG_W = touch_pkg::CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic [RAW_W-1:0] diff,
  input  logic [CFG_W-1:0] finger_th,
  input  logic [CFG_W-1:0] hyst,
  input  logic [CFG_W-1:0] debounce,
  output logic             touch
);
  logic             touch_q, touch_d;
  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic [CFG_W:0]   on_lvl, c1, lim;
  logic             qual, off;

  always_comb begin
    on_lvl  = {1'b0, finger_th} + {1'b0, hyst};
    qual    = diff >= RAW_W'(on_lvl);
    off     = ((RAW_W+1)'(diff) + (RAW_W+1)'(hyst)) < (RAW_W+1)'(finger_th);
    c1      = {1'b0, cnt_q} + {{CFG_W{1'b0}}, 1'b1};
    lim     = (debounce == '0) ? {{CFG_W{1'b0}}, 1'b1} : {1'b0, debounce};
    touch_d = touch_q;
    cnt_d   = cnt_q;
    if (eval) begin
      if (touch_q) begin
        if (off) begin
          touch_d = 1'b0;
          cnt_d   = '0;
        end
      end else if (qual) begin
        if (c1 >= lim) begin
          touch_d = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = c1[CFG_W-1:0];
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touch_q <= 1'b0;
      cnt_q   <= '0;
    end else if (eval) begin
      touch_q <= touch_d;
      cnt_q   <= cnt_d;
    end
  end

  assign touch = touch_q;
endmodule

// File: rtl/touch_detect.sv
module touch_detect #(
  parameter int RAW_W = touch_pkg::RAW_W_DEF,
  parameter int CFG_W = touch_pkg::CFG_W_DEF,
  parameter int ORD_W = touch_pkg::ORD_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [RAW_W-1:0] smp_raw,
  input  logic             cfg_avg_en,
  input  logic [ORD_W-1:0] cfg_avg_ord,
  input  logic [CFG_W-1:0] cfg_finger_th,
  input  logic [CFG_W-1:0] cfg_hyst,
  input  logic [CFG_W-1:0] cfg_debounce,
  input  logic [CFG_W-1:0] cfg_noise_th,
  input  logic [CFG_W-1:0] cfg_bucket_th,
  input  logic [CFG_W-1:0] cfg_neg_th,
  input  logic [CFG_W-1:0] cfg_low_rst,
  input  logic             cfg_auto_rst,
  output logic             touch,
  output logic [RAW_W-1:0] raw_out,
  output logic [RAW_W-1:0] base_out,
  output logic [RAW_W-1:0] diff_out
);
  logic [RAW_W-1:0] filt;
  logic [RAW_W-1:0] base_now;
  logic             base_init;
  logic [RAW_W-1:0] diff_now;
  logic [RAW_W-1:0] raw_q, diff_q;

  touch_avg #(.RAW_W(RAW_W), .ORD_W(ORD_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_raw(smp_raw),
    .avg_en(cfg_avg_en), .avg_ord(cfg_avg_ord), .filt(filt)
  );

  touch_base #(.RAW_W(RAW_W), .CFG_W(CFG_W)) u_base (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .filt(filt),
    .touched(touch), .noise_th(cfg_noise_th), .bucket_th(cfg_bucket_th),
    .neg_th(cfg_neg_th), .low_rst(cfg_low_rst), .auto_rst(cfg_auto_rst),
    .base(base_now), .init(base_init)
  );

  assign diff_now = (base_init && (filt >= base_now)) ? (filt - base_now) : '0;

  touch_deb #(.RAW_W(RAW_W), .CFG_W(CFG_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .eval(smp_vld && base_init), .diff(diff_now),
    .finger_th(cfg_finger_th), .hyst(cfg_hyst), .debounce(cfg_debounce),
    .touch(touch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      diff_q <= '0;
    end else if (smp_vld) begin
      raw_q  <= filt;
      diff_q <= diff_now;
    end
  end

  assign raw_out  = raw_q;
  assign diff_out = diff_q;
  assign base_out = base_now;
endmodule

// File: rtl/touch_detect_chk.sv
module touch_detect_chk #(
  parameter int RAW_W = touch_pkg::RAW_W_DEF,
  parameter int CFG_W = touch_pkg::CFG_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld,
  input logic             base_init,
  input logic             cfg_auto_rst,
  input logic [CFG_W-1:0] cfg_finger_th,
  input logic [CFG_W-1:0] cfg_hyst,
  input logic             touch,
  input logic [RAW_W-1:0] raw_out,
  input logic [RAW_W-1:0] base_out,
  input logic [RAW_W-1:0] diff_out
);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> ($stable(raw_out) && $stable(base_out) && $stable(diff_out) && $stable(touch)));

  // R5
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(base_init) && (base_out > $past(base_out))) |-> (base_out == $past(base_out) + RAW_W'(1)));

  // R10
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(touch) |-> (base_out <= $past(base_out)));

  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_rst && !$past(cfg_auto_rst) && $past(base_init)) |-> (base_out >= $past(base_out)));

  // R8
  touch_on_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(touch) |-> (diff_out >= RAW_W'(cfg_finger_th) + RAW_W'(cfg_hyst)));

  // R9
  touch_off_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(touch) |-> (((RAW_W+1)'(diff_out) + (RAW_W+1)'(cfg_hyst)) < (RAW_W+1)'(cfg_finger_th)));
endmodule

bind touch_detect touch_detect_chk #(.RAW_W(RAW_W), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .base_init(base_init),
  .cfg_auto_rst(cfg_auto_rst), .cfg_finger_th(cfg_finger_th), .cfg_hyst(cfg_hyst),
  .touch(touch), .raw_out(raw_out), .base_out(base_out), .diff_out(diff_out)
);

// File: tb/touch_detect_tb_top.sv
`timescale 1ns/1ps
module touch_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_raw = '0;
  logic        cfg_avg_en = 1'b0;
  logic [1:0]  cfg_avg_ord = '0;
  logic [7:0]  cfg_finger_th = 8'd255, cfg_hyst = 8'd0, cfg_debounce = 8'd1;
  logic [7:0]  cfg_noise_th = 8'd0, cfg_bucket_th = 8'd100, cfg_neg_th = 8'd255;
  logic [7:0]  cfg_low_rst = 8'd10;
  logic        cfg_auto_rst = 1'b0;
  logic        touch;
  logic [15:0] raw_out, base_out, diff_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_init = 0, m_base = 0, m_bucket = 0, m_neg = 0, m_touch = 0, m_cnt = 0;
  int m_hist [7];
  int e_raw = 0, e_diff = 0;

  always #2.5 clk = ~clk;

  touch_detect dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_raw(smp_raw),
    .cfg_avg_en(cfg_avg_en), .cfg_avg_ord(cfg_avg_ord), .cfg_finger_th(cfg_finger_th),
    .cfg_hyst(cfg_hyst), .cfg_debounce(cfg_debounce), .cfg_noise_th(cfg_noise_th),
    .cfg_bucket_th(cfg_bucket_th), .cfg_neg_th(cfg_neg_th), .cfg_low_rst(cfg_low_rst),
    .cfg_auto_rst(cfg_auto_rst), .touch(touch), .raw_out(raw_out),
    .base_out(base_out), .diff_out(diff_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic model(int r);
    int n, s, f, d, nt, c, bs, lim;
    n = 1 << cfg_avg_ord;
    s = r;
    for (int k = 0; k < n - 1; k++) s += m_hist[k];
    f = cfg_avg_en ? s / n : r;
    for (int k = 6; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = r;
    d = (m_init != 0 && f >= m_base) ? f - m_base : 0;
    nt = m_touch;
    if (m_init != 0) begin
      if (m_touch != 0) begin
        if (d + cfg_hyst < cfg_finger_th) begin nt = 0; m_cnt = 0; end
      end else if (d >= cfg_finger_th + cfg_hyst) begin
        c = m_cnt + 1;
        lim = (cfg_debounce == 0) ? 1 : cfg_debounce;
        if (c >= lim) begin nt = 1; m_cnt = 0; end else m_cnt = c;
      end else m_cnt = 0;
    end
    if (m_init == 0) begin
      m_base = f; m_init = 1; m_bucket = 0; m_neg = 0;
    end else if (f >= m_base) begin
      m_neg = 0;
      if (m_touch == 0 && (f - m_base) < cfg_noise_th) begin
        bs = m_bucket + (f - m_base);
        if (bs >= cfg_bucket_th) begin
          m_bucket = 0;
          if (m_base != 65535) m_base++;
        end else m_bucket = bs;
      end
    end else if (m_base - f > cfg_neg_th) begin
      c = m_neg + 1;
      lim = (cfg_low_rst == 0) ? 1 : cfg_low_rst;
      if (cfg_auto_rst && c >= lim) begin
        m_base = f; m_neg = 0; m_bucket = 0;
      end else m_neg = (c > 255) ? 255 : c;
    end else m_neg = 0;
    e_raw = f; e_diff = d; m_touch = nt;
  endtask

  task automatic push(int r, string btag, string ttag);
    @(negedge clk);
    smp_vld = 1'b1;
    smp_raw = 16'(r);
    model(r);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R4 raw_out", int'(raw_out), e_raw);
    chk("R3 diff_out", int'(diff_out), e_diff);
    chk({btag, " base_out"}, int'(base_out), m_base);
    chk({ttag, " touch"}, int'(touch), m_touch);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) m_hist[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk("R1 touch", int'(touch), 0);
    chk("R1 raw_out", int'(raw_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 base_out", int'(base_out), 0);
    chk("R1 diff_out", int'(diff_out), 0);

    // R2 first sample loads baseline
    push(1000, "R2", "R2");

    // R4 averaging sweep: all orders, with and without averaging
    for (int en = 0; en < 2; en++) begin
      for (int o = 0; o < 4; o++) begin
        cfg_avg_en = en[0];
        cfg_avg_ord = 2'(o);
        for (int k = 0; k < 12; k++) push(1000 + (k * 37 + o * 11) % 53, "R4", "R4");
      end
    end

    // R3 outputs hold without a strobe
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      smp_raw = 16'(7 + k * 900);
      @(negedge clk);
      chk("R3 idle raw_out", int'(raw_out), e_raw);
      chk("R3 idle base_out", int'(base_out), m_base);
      chk("R3 idle diff_out", int'(diff_out), e_diff);
    end

    // R5 bucket drift tracking
    cfg_avg_en = 1'b0;
    cfg_noise_th = 8'd10; cfg_bucket_th = 8'd20;
    cfg_finger_th = 8'd200; cfg_hyst = 8'd0;
    for (int k = 0; k < 10; k++) push(m_base + 5, "R5", "R5");
    for (int k = 0; k < 4; k++) push(m_base + 9, "R5", "R5");
    for (int k = 0; k < 4; k++) push(m_base + 10, "R5", "R5");

    // R8 debounce with restart
    cfg_finger_th = 8'd50; cfg_hyst = 8'd10; cfg_debounce = 8'd3;
    push(m_base + 60, "R8", "R8");
    push(m_base + 60, "R8", "R8");
    push(m_base + 59, "R8", "R8");
    push(m_base + 60, "R8", "R8");
    push(m_base + 60, "R8", "R8");
    push(m_base + 60, "R8", "R8");

    // R10 touched: small differences do not move the baseline
    cfg_noise_th = 8'd100; cfg_bucket_th = 8'd1;
    for (int k = 0; k < 6; k++) push(m_base + 45, "R10", "R10");

    // R9 release boundary
    push(m_base + 40, "R9", "R9");
    push(m_base + 39, "R9", "R9");

    // R8 debounce of zero acts as one
    cfg_noise_th = 8'd0; cfg_debounce = 8'd0;
    push(m_base + 60, "R8", "R8");

    // R6 and R9 in the same sample: reload while releasing
    cfg_auto_rst = 1'b1; cfg_neg_th = 8'd20; cfg_low_rst = 8'd0;
    push(m_base - 30, "R6", "R9");

    // R6 consecutive count with restart
    cfg_low_rst = 8'd3;
    push(m_base - 30, "R6", "R6");
    push(m_base - 30, "R6", "R6");
    push(m_base - 20, "R6", "R6");
    push(m_base - 30, "R6", "R6");
    push(m_base - 30, "R6", "R6");
    push(m_base - 30, "R6", "R6");

    // R7 auto-reset disabled
    cfg_auto_rst = 1'b0; cfg_low_rst = 8'd1;
    for (int k = 0; k < 5; k++) push(m_base - 100, "R7", "R7");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule